// File: doc/BRIEF.md
# Dual-Port Four-Beat Burst Synchronous Memory

This block is a synthesizable, small-depth model of a static memory with one read port and one write port. The two ports work independently and may both start a transfer on the same command edge. Data always moves as a burst of four words at double rate, one word per half command period. A burst therefore takes two command periods. The design runs on a beat clock that is twice the command-clock rate. A phase input, `cmd_edge`, is high on the beats that stand for a rising edge of the command clock. Commands are taken only on those beats.

A read returns its first word one and a half command periods after its command, and the other three words follow on the next beats. Write data comes after its address: the write command is given first, and the four data words with their lane enables follow one command period later. Each 9-bit lane of each word can be masked. Reads are coherent. A read sees every write whose command was taken on the same edge as the read or on an earlier edge, even when that write's data had not arrived when the read was accepted.

The word width `DW` is 18 or 36 bits, which gives two or four 9-bit lanes. The burst address is `BAW` bits wide, so the array holds 4·2^BAW words.

Top module: `qburst_sram`

## Requirements
- R1: A synchronous active-low reset `rst_n` clears `rvalid` and `rdata` to 0 and drops every accepted burst that has not finished. Array contents are kept.
- R2: The selects `rd_sel_n` and `wr_sel_n` are active low and are sampled only on clock edges where `cmd_edge` is 1. A select that is low on any other edge has no effect.
- R3: A read taken at edge t with burst address A drives word A·4+k on `rdata` with `rvalid`=1 after edges t+3+k, for k=0..3. `rvalid` stays high for exactly those four beats.
- R4: A write taken at edge t with burst address A stores `wdata` sampled at edge t+2+k into word A·4+k, for k=0..3, so word k is taken on the k-th beat after the next command edge.
- R5: Bit j of `wbe_n` (0 = write) guards bits 9j+8..9j of the word sampled on the same edge. Masked lanes keep their old contents.
- R6: After a port accepts a command at edge t, further selects on that port at edges t+1..t+3 are ignored. A select at t+4 is accepted.
- R7: A read and a write taken on the same edge both complete, with the timing of R3 and R4.
- R8: A read returns the data of every write taken on the same edge as the read or on an earlier edge, including the lane merge of R5, even when that write's data had not yet arrived at the read's command edge.
- R9: `rdata` is all zeros on every beat where `rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, twice the command rate |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_edge | input | 1 | High on beats that are command-clock rising edges |
| rd_sel_n | input | 1 | Read select, active low |
| rd_addr | input | BAW | Read burst address |
| wr_sel_n | input | 1 | Write select, active low |
| wr_addr | input | BAW | Write burst address |
| wdata | input | DW | Write data, one word per beat |
| wbe_n | input | DW/9 | Lane write enables, active low |
| rdata | output | DW | Read data, one word per beat |
| rvalid | output | 1 | High while a read word is on rdata |

## Verification
The bench first fills the array with spaced write bursts and reads it back with spaced read bursts. This separates correct word order and latency from shifted or reversed beats. Reads and writes are then issued on the same edge, to different addresses and to the same address, and reads are issued one command period after a write to the same burst. These patterns tell a design that returns stale array data apart from a coherent one. Bursts with random lane masks check that masked lanes are preserved. Selects are also sent on every command edge, and on edges where `cmd_edge` is low, which exposes a port that accepts commands while busy or off phase. A reset in the middle of a burst shows whether in-flight work is dropped.

// File: rtl/qburst_sram.sv
`timescale 1ns/1ps
module qburst_sram #(
  parameter int DW  = 36,
  parameter int BAW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_edge,
  input  logic            rd_sel_n,
  input  logic [BAW-1:0]  rd_addr,
  input  logic            wr_sel_n,
  input  logic [BAW-1:0]  wr_addr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW/9-1:0] wbe_n,
  output logic [DW-1:0]   rdata,
  output logic            rvalid
);
  localparam int LANES = DW / 9;
  localparam int MAW   = BAW + 2;
  localparam int DEPTH = 1 << MAW;

  logic [DW-1:0]  mem [DEPTH];
  logic [6:1]     rv;
  logic [5:1]     wv;
  logic [BAW-1:0] ra [1:6];
  logic [BAW-1:0] wa [1:5];

  wire rd_go = cmd_edge && !rd_sel_n && !(|rv[3:1]);
  wire wr_go = cmd_edge && !wr_sel_n && !(|wv[3:1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv <= '0;
      wv <= '0;
    end else begin
      rv <= {rv[5:1], rd_go};
      wv <= {wv[4:1], wr_go};
    end
  end

  always_ff @(posedge clk) begin
    ra[1] <= rd_addr;
    wa[1] <= wr_addr;
    for (int i = 2; i <= 6; i++) ra[i] <= ra[i-1];
    for (int i = 2; i <= 5; i++) wa[i] <= wa[i-1];
  end

  logic           rhit, whit;
  logic [MAW-1:0] rloc, wloc;

  always_comb begin
    rhit = 1'b0;
    rloc = '0;
    whit = 1'b0;
    wloc = '0;
    for (int k = 0; k < 4; k++) begin
      if (rv[3+k]) begin
        rhit = 1'b1;
        rloc = {ra[3+k], 2'(k)};
      end
      if (wv[2+k]) begin
        whit = 1'b1;
        wloc = {wa[2+k], 2'(k)};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && whit)
      for (int j = 0; j < LANES; j++)
        if (!wbe_n[j]) mem[wloc][j*9 +: 9] <= wdata[j*9 +: 9];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rhit;
      rdata  <= rhit ? mem[rloc] : '0;
    end
  end

  assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);

  assert_read_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rv[4:1]));

  assert_write_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wv[4:1]));

  assert_edge_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_edge |=> !rv[1] && !wv[1]);

  assert_burst_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |=> rvalid ##1 rvalid ##1 rvalid);
endmodule

// File: tb/qburst_sram_test.sv
`timescale 1ns/1ps
module qburst_sram_test;
  localparam int DW = 36, BAW = 6, LN = DW / 9;

  logic clk = 0, rst_n = 0, cmd_edge = 0, rd_sel_n = 1, wr_sel_n = 1;
  logic [BAW-1:0] rd_addr = '0, wr_addr = '0;
  logic [DW-1:0]  wdata = '0;
  logic [LN-1:0]  wbe_n = '1;
  logic [DW-1:0]  rdata;
  logic           rvalid;

  qburst_sram #(.DW(DW), .BAW(BAW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_edge(cmd_edge),
    .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
    .wr_sel_n(wr_sel_n), .wr_addr(wr_addr),
    .wdata(wdata), .wbe_n(wbe_n), .rdata(rdata), .rvalid(rvalid));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  string req = "R1";
  bit mask_on = 0, done = 0;
  logic [63:0] rnd;

  always @(negedge clk) begin
    cmd_edge <= rst_n ? !cmd_edge : 1'b0;
    rnd = {$urandom, $urandom};
    wdata <= rnd[DW-1:0];
    wbe_n <= mask_on ? rnd[DW+LN-1:DW] : '0;
  end

  // behavioural reference
  logic [DW-1:0] mm [256];
  int n = 0, lr = -100, lw = -100;
  bit rdv [16], wdv [16];
  int rda [16], wda [16];
  logic ev = 0;
  logic [DW-1:0] ed = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin rdv[i] = 0; wdv[i] = 0; end
      lr = -100; lw = -100; ev = 0; ed = '0;
    end else begin
      if (wdv[n%16]) begin
        for (int j = 0; j < LN; j++)
          if (!wbe_n[j]) mm[wda[n%16]][j*9 +: 9] = wdata[j*9 +: 9];
        wdv[n%16] = 0;
      end
      if (rdv[n%16]) begin ev = 1; ed = mm[rda[n%16]]; rdv[n%16] = 0; end
      else begin ev = 0; ed = '0; end
      if (cmd_edge && !rd_sel_n && n - lr >= 4) begin
        for (int k = 0; k < 4; k++) begin
          rdv[(n+3+k)%16] = 1; rda[(n+3+k)%16] = int'(rd_addr) * 4 + k;
        end
        lr = n;
      end
      if (cmd_edge && !wr_sel_n && n - lw >= 4) begin
        for (int k = 0; k < 4; k++) begin
          wdv[(n+2+k)%16] = 1; wda[(n+2+k)%16] = int'(wr_addr) * 4 + k;
        end
        lw = n;
      end
    end
    n++;
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rvalid !== ev || rdata !== ed) begin
        errors++;
        $display("FAIL %s%s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                 req, ev ? "" : " R9", rvalid, rdata, ev, ed);
      end
    end
  end

  task automatic cmd(input bit r, input int ra, input bit w, input int wa);
    @(negedge clk); #1;
    while (!cmd_edge) begin @(negedge clk); #1; end
    rd_sel_n = !r; rd_addr = ra[BAW-1:0];
    wr_sel_n = !w; wr_addr = wa[BAW-1:0];
    @(negedge clk); #1;
    rd_sel_n = 1; wr_sel_n = 1;
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic expect_quiet(input string r, input int beats);
    repeat (beats) begin
      @(negedge clk); #2;
      checks++;
      if (rvalid !== 1'b0 || rdata !== '0) begin
        errors++;
        $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=0 rdata=0", r, rvalid, rdata);
      end
    end
  endtask

  task automatic read_range(input int lo, input int cnt);
    for (int a = lo; a < lo + cnt; a++) begin cmd(1, a % 64, 0, 0); cmd(0, 0, 0, 0); end
    idle(10);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL R1 watchdog: actual run still busy expected finished");
    summary();
    $finish;
  end

  initial begin
    idle(4); #1 rst_n = 1;
    expect_quiet("R1", 3);

    req = "R4";
    for (int a = 0; a < 64; a++) begin cmd(0, 0, 1, a); cmd(0, 0, 0, 0); end
    idle(8);
    req = "R3";
    read_range(0, 64);

    req = "R7";
    for (int i = 0; i < 8; i++) begin cmd(1, i, 1, 40 + i); cmd(0, 0, 0, 0); end
    idle(8);
    read_range(40, 8);

    req = "R8";
    for (int i = 0; i < 6; i++) begin cmd(1, 10 + i, 1, 10 + i); cmd(0, 0, 0, 0); end
    for (int i = 0; i < 6; i++) begin cmd(0, 0, 1, 20 + i); cmd(1, 20 + i, 0, 0); end
    idle(10);

    req = "R5";
    mask_on = 1;
    for (int a = 0; a < 16; a++) begin cmd(0, 0, 1, a); cmd(0, 0, 0, 0); end
    mask_on = 0;
    idle(8);
    read_range(0, 16);

    req = "R6";
    for (int i = 0; i < 16; i++) cmd(1, i, 1, 50 + i);
    idle(10);
    read_range(50, 16);

    req = "R2";
    @(negedge clk); #1;
    while (cmd_edge) begin @(negedge clk); #1; end
    rd_sel_n = 0; rd_addr = 6'd3; wr_sel_n = 0; wr_addr = 6'd3;
    @(negedge clk); #1;
    rd_sel_n = 1; wr_sel_n = 1;
    expect_quiet("R2", 10);
    read_range(3, 1);

    req = "R1";
    cmd(1, 5, 1, 6);
    idle(2);
    #1 rst_n = 0;
    idle(3);
    #1 rst_n = 1;
    expect_quiet("R1", 10);

    done = 1;
    summary();
    $finish;
  end
endmodule